// File: doc/BRIEF.md
# Banked Read Memory with Lane Crossbar and Write-Back Tracking

This block holds the data of a many-lane load unit in a set of independent 32-bit memory banks. It serves one already resolved wavefront per cycle. A wavefront gives each bank one row to read and a mask of the lanes that want that bank's word. Every bank reads its row in the same cycle. A crossbar then hands each bank's word to every lane named in its mask, so one word can reach many lanes at once.

Each lane's word is shaped for the load width: a byte or a halfword is selected by the lane's byte offset and then sign- or zero-extended. A word is extended to 64 bits. A doubleword is taken from two neighbouring banks. The shaped results of one wavefront form one entry in a small write-back FIFO, which drains toward the register file under a valid/ready handshake.

An instruction is opened with the set of lanes it expects. Its results may arrive over several wavefronts. A single retire pulse is raised once the FIFO has handed over every expected lane. A plain write port preloads the banks. Deciding which lanes share a wavefront is the job of the logic upstream.

Top module: `banked_lane_xbar`

## Requirements
- R1: After reset, `wb_valid`, `retire` and `wf_ready` are low and no instruction is open.
- R2: A write on the preload port stores `wr_data` at row `wr_row` of bank `wr_bank`. A wavefront accepted on the same edge still reads the value held before that write. Each bank reads the row given in its own field `wf_rows[b*RW +: RW]`, without regard to the rows of the other banks.
- R3: Lane l receives the word of bank b when bit `b*LANES + l` of `wf_masks` is set. When several banks name the same lane, the lowest numbered bank wins. One bank can feed any number of lanes in the same wavefront.
- R4: With size code 0 (byte), a lane with byte offset o (`wf_offs[2l+1:2l]`) gets bits [8o+7:8o] of its word. The value is sign-extended to 64 bits when the instruction's signed flag is 1 and zero-extended otherwise.
- R5: With size code 1 (halfword), offset bit 1 picks the upper half (1) or the lower half (0) of the word. Offset bit 0 is ignored. The result is extended as in R4.
- R6: With size code 2 (word), the 32-bit word is extended to 64 bits as in R4. With size code 3 (doubleword), the lane gets the word of bank (b+1) mod NB at the row requested for that bank in bits [63:32], and its own bank's word in bits [31:0].
- R7: A wavefront accepted on an edge becomes visible on the write-back port two edges later when the FIFO is empty. `wb_lanes` is the set of lanes named in any mask, and the 64-bit data of every other lane is zero.
- R8: Write-back entries leave in acceptance order. While `wb_ready` is low, the head entry is held unchanged. `wf_ready` is low whenever FIFO entries plus the wavefront in flight reach DEPTH.
- R9: `inst_start` while no instruction is open latches `inst_lanes`, `inst_size` and `inst_signed`; while one is open it is ignored. `retire` is high for exactly the one cycle after the handover that completes every expected lane, and that closes the instruction. An empty expected set retires in the cycle after the start.
- R10: `wf_ready` is low while no instruction is open, so wavefronts offered then are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Preload write strobe |
| wr_bank | input | BW | Bank of the preload write |
| wr_row | input | RW | Row of the preload write |
| wr_data | input | 32 | Preload write word |
| inst_start | input | 1 | Open an instruction |
| inst_lanes | input | LANES | Lanes the instruction expects |
| inst_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| inst_signed | input | 1 | Sign-extend sub-doubleword results |
| wf_valid | input | 1 | A wavefront is offered |
| wf_ready | output | 1 | Wavefront accepted on this edge if valid |
| wf_rows | input | NB*RW | Row per bank |
| wf_masks | input | NB*LANES | Lane mask per bank |
| wf_offs | input | 2*LANES | Byte offset per lane |
| wb_valid | output | 1 | Write-back head entry present |
| wb_ready | input | 1 | Register file takes the head entry |
| wb_lanes | output | LANES | Lanes carried by the head entry |
| wb_data | output | 64*LANES | 64-bit result per lane |
| retire | output | 1 | One-cycle instruction retirement pulse |

## Verification
The bench builds the block with its full 32 banks and 32 lanes, so crossbar selection and the wrap of the doubleword neighbour from bank 31 to bank 0 are exercised at their real size. It uses 8 rows and a write-back depth of 2. The small depth means a stalled register file blocks acceptance after only two wavefronts, so the full-FIFO back-pressure is reached within a few cycles. Retirement over split wavefronts, ignored restarts, empty instructions and preload writes colliding with reads are all driven against the model under random stalls.

// File: rtl/banked_lane_xbar.sv
module banked_lane_xbar #(
  parameter int NB    = 32,
  parameter int LANES = 32,
  parameter int ROWS  = 16,
  parameter int DEPTH = 2,
  localparam int BW = $clog2(NB),
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [BW-1:0]         wr_bank,
  input  logic [RW-1:0]         wr_row,
  input  logic [31:0]           wr_data,
  input  logic                  inst_start,
  input  logic [LANES-1:0]      inst_lanes,
  input  logic [1:0]            inst_size,
  input  logic                  inst_signed,
  input  logic                  wf_valid,
  output logic                  wf_ready,
  input  logic [NB*RW-1:0]      wf_rows,
  input  logic [NB*LANES-1:0]   wf_masks,
  input  logic [2*LANES-1:0]    wf_offs,
  output logic                  wb_valid,
  input  logic                  wb_ready,
  output logic [LANES-1:0]      wb_lanes,
  output logic [64*LANES-1:0]   wb_data,
  output logic                  retire
);

  logic                 busy;
  logic [LANES-1:0]     exp_q, acc_q;
  logic [1:0]           size_q;
  logic                 sgn_q;
  logic                 s1_valid;
  logic [BW-1:0]        s1_sel [LANES];
  logic [LANES-1:0]     s1_hit;
  logic [2*LANES-1:0]   s1_off;
  logic [BW-1:0]        sel0 [LANES];
  logic [LANES-1:0]     hit0;
  logic [NB*32-1:0]     rd_flat;
  logic [64*LANES-1:0]  lane_res;
  logic [64*LANES-1:0]  fd [DEPTH];
  logic [LANES-1:0]     fm [DEPTH];
  logic [PW-1:0]        wp, rp;
  logic [CW-1:0]        cnt;

  wire accept = wf_valid && wf_ready;
  wire push   = s1_valid;
  wire pop    = wb_valid && wb_ready;

  assign wb_valid = (cnt != '0);
  assign wb_lanes = fm[rp];
  assign wb_data  = fd[rp];
  assign wf_ready = busy && (({1'b0, cnt} + (CW+1)'(s1_valid)) < (CW+1)'(DEPTH));

  // banks: one row per bank per cycle, read data registered
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [31:0] mem [ROWS];
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == BW'(b)) mem[wr_row] <= wr_data;
      if (accept) q <= mem[wf_rows[b*RW +: RW]];
    end
    assign rd_flat[b*32 +: 32] = q;
  end

  // lane select: lowest bank naming the lane wins
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      sel0[l] = '0;
      hit0[l] = 1'b0;
      for (int b = NB - 1; b >= 0; b--) begin
        if (wf_masks[b*LANES + l]) begin
          sel0[l] = BW'(b);
          hit0[l] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_sel <= sel0;
      s1_hit <= hit0;
      s1_off <= wf_offs;
    end
  end

  // crossbar and sub-word shaping
  always_comb begin : p_shape
    logic [31:0] w, hi, sh;
    logic [15:0] hw;
    logic [1:0]  off;
    logic [63:0] res;
    int          nxt;
    for (int l = 0; l < LANES; l++) begin
      nxt = (int'(s1_sel[l]) == NB - 1) ? 0 : int'(s1_sel[l]) + 1;
      w   = rd_flat[int'(s1_sel[l])*32 +: 32];
      hi  = rd_flat[nxt*32 +: 32];
      off = s1_off[2*l +: 2];
      sh  = w >> {off, 3'b000};
      hw  = off[1] ? w[31:16] : w[15:0];
      case (size_q)
        2'd0:    res = {{56{sgn_q & sh[7]}}, sh[7:0]};
        2'd1:    res = {{48{sgn_q & hw[15]}}, hw};
        2'd2:    res = {{32{sgn_q & w[31]}}, w};
        default: res = {hi, w};
      endcase
      lane_res[64*l +: 64] = s1_hit[l] ? res : 64'd0;
    end
  end

  // write-back FIFO
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      fd[wp] <= lane_res;
      fm[wp] <= s1_hit;
    end
  end

  // instruction tracking and retirement
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      retire <= 1'b0;
      exp_q  <= '0;
      acc_q  <= '0;
      size_q <= 2'd0;
      sgn_q  <= 1'b0;
    end else begin
      retire <= 1'b0;
      if (inst_start && !busy) begin
        exp_q  <= inst_lanes;
        acc_q  <= '0;
        size_q <= inst_size;
        sgn_q  <= inst_signed;
        if (inst_lanes == '0) retire <= 1'b1;
        else                  busy   <= 1'b1;
      end else if (busy && pop) begin
        if (((acc_q | wb_lanes) & exp_q) == exp_q) begin
          retire <= 1'b1;
          busy   <= 1'b0;
        end else begin
          acc_q <= acc_q | wb_lanes;
        end
      end
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (cnt < CW'(DEPTH)));

  assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_lanes) && $stable(wb_data)));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 wb_valid);

  assert_retire_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);

  assert_retire_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> !wf_ready);

endmodule

// File: tb/test_banked_lane_xbar.sv
module test_banked_lane_xbar;
  localparam int NB = 32, LANES = 32, ROWS = 8, DEPTH = 2;
  localparam int BW = $clog2(NB), RW = $clog2(ROWS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [BW-1:0] wr_bank = '0;
  logic [RW-1:0] wr_row = '0;
  logic [31:0] wr_data = '0;
  logic inst_start = 1'b0, inst_signed = 1'b0;
  logic [LANES-1:0] inst_lanes = '0;
  logic [1:0] inst_size = 2'd2;
  logic wf_valid = 1'b0, wf_ready;
  logic [NB*RW-1:0] wf_rows = '0;
  logic [NB*LANES-1:0] wf_masks = '0;
  logic [2*LANES-1:0] wf_offs = '0;
  logic wb_valid, wb_ready = 1'b1, retire;
  logic [LANES-1:0] wb_lanes;
  logic [64*LANES-1:0] wb_data;

  banked_lane_xbar #(.NB(NB), .LANES(LANES), .ROWS(ROWS), .DEPTH(DEPTH)) i_banked_lane_xbar (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row),
    .wr_data(wr_data), .inst_start(inst_start), .inst_lanes(inst_lanes),
    .inst_size(inst_size), .inst_signed(inst_signed), .wf_valid(wf_valid),
    .wf_ready(wf_ready), .wf_rows(wf_rows), .wf_masks(wf_masks), .wf_offs(wf_offs),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_lanes(wb_lanes), .wb_data(wb_data),
    .retire(retire));

  always #5 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] mmem [NB][ROWS];
  logic [LANES-1:0] qm [$];
  logic [64*LANES-1:0] qd [$];
  bit m_inf = 0, m_busy = 0, m_ret = 0, m_sgn = 0, last_acc = 0;
  logic [LANES-1:0] m_im, m_exp, m_acc;
  logic [64*LANES-1:0] m_id;
  logic [1:0] m_size = 2'd0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog %s act=%0d exp=finish", cur_req, cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [64*LANES-1:0] act,
                     input logic [64*LANES-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] shape(input logic [31:0] w, input logic [31:0] hi,
                                        input logic [1:0] off, input logic [1:0] sz, input bit sg);
    logic [63:0] v;
    case (sz)
      2'd0: begin v = 64'((w >> (8 * off)) & 32'hff);  if (sg && v[7])  v = v | ~64'hff; end
      2'd1: begin v = off[1] ? 64'(w >> 16) : 64'(w & 32'hffff); if (sg && v[15]) v = v | ~64'hffff; end
      2'd2: begin v = 64'(w); if (sg && w[31]) v = v | ~64'hffff_ffff; end
      default: v = {hi, w};
    endcase
    return v;
  endfunction

  task automatic tick();
    bit rdy, pop, acc, nret;
    logic [LANES-1:0] pl, hits;
    logic [64*LANES-1:0] ent;
    rdy = m_busy && ((qm.size() + (m_inf ? 1 : 0)) < DEPTH);
    chk(wf_ready === rdy, "wf_ready", 64*LANES'(wf_ready), 64*LANES'(rdy));
    chk(wb_valid === (qm.size() > 0), "wb_valid", 64*LANES'(wb_valid), 64*LANES'(qm.size() > 0));
    chk(retire === m_ret, "retire", 64*LANES'(retire), 64*LANES'(m_ret));
    if (qm.size() > 0) begin
      chk(wb_lanes === qm[0], "wb_lanes", 64*LANES'(wb_lanes), 64*LANES'(qm[0]));
      chk(wb_data === qd[0], "wb_data", wb_data, qd[0]);
    end
    pop = (qm.size() > 0) && wb_ready;
    acc = wf_valid && rdy;
    last_acc = acc;
    if (acc) begin
      hits = '0;
      ent = '0;
      for (int l = 0; l < LANES; l++) begin
        for (int b = 0; b < NB; b++) begin
          if (wf_masks[b*LANES + l] && !hits[l]) begin
            int nb;
            nb = (b + 1) % NB;
            hits[l] = 1'b1;
            ent[64*l +: 64] = shape(mmem[b][wf_rows[b*RW +: RW]], mmem[nb][wf_rows[nb*RW +: RW]],
                                    wf_offs[2*l +: 2], m_size, m_sgn);
          end
        end
      end
    end
    nret = 0;
    pl = (qm.size() > 0) ? qm[0] : '0;
    if (inst_start && !m_busy) begin
      m_exp = inst_lanes; m_acc = '0; m_size = inst_size; m_sgn = inst_signed;
      if (inst_lanes == '0) nret = 1; else m_busy = 1;
    end else if (m_busy && pop) begin
      if (((m_acc | pl) & m_exp) == m_exp) begin nret = 1; m_busy = 0; end
      else m_acc = m_acc | pl;
    end
    m_ret = nret;
    if (pop) begin void'(qm.pop_front()); void'(qd.pop_front()); end
    if (m_inf) begin qm.push_back(m_im); qd.push_back(m_id); end
    m_inf = acc;
    if (acc) begin m_im = hits; m_id = ent; end
    if (wr_en) mmem[wr_bank][wr_row] = wr_data;
    @(posedge clk); #2;
  endtask

  task automatic start(input logic [LANES-1:0] lanes, input logic [1:0] sz, input bit sg);
    inst_start = 1; inst_lanes = lanes; inst_size = sz; inst_signed = sg;
    tick();
    inst_start = 0;
  endtask

  task automatic send(input logic [NB*LANES-1:0] m, input logic [NB*RW-1:0] r,
                      input logic [2*LANES-1:0] o);
    wf_valid = 1; wf_masks = m; wf_rows = r; wf_offs = o;
    for (int k = 0; k < 200; k++) begin
      tick();
      if (last_acc) break;
    end
    wf_valid = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 300; k++) begin
      if (!m_busy && qm.size() == 0 && !m_inf && !m_ret) break;
      tick();
    end
    tick();
  endtask

  function automatic logic [NB*RW-1:0] rrows();
    logic [NB*RW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*RW +: RW] = RW'($urandom);
    return r;
  endfunction

  function automatic logic [2*LANES-1:0] roffs();
    logic [2*LANES-1:0] o;
    for (int l = 0; l < LANES; l++) o[2*l +: 2] = 2'($urandom);
    return o;
  endfunction

  function automatic logic [NB*LANES-1:0] rmask(input logic [LANES-1:0] lanes);
    logic [NB*LANES-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++)
      if (lanes[l]) m[int'($urandom % NB)*LANES + l] = 1'b1;
    return m;
  endfunction

  task automatic one_inst(input logic [LANES-1:0] lanes, input logic [1:0] sz, input bit sg);
    logic [LANES-1:0] a;
    start(lanes, sz, sg);
    a = lanes & LANES'($urandom);
    send(rmask(a), rrows(), roffs());
    send(rmask(lanes & ~a), rrows(), roffs());
    drain();
  endtask

  initial begin
    logic [NB*LANES-1:0] m;
    for (int b = 0; b < NB; b++) for (int r = 0; r < ROWS; r++) mmem[b][r] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: reset state
    cur_req = "R1";
    tick(); tick();
    // R10: wavefront offered with no instruction open is not taken
    cur_req = "R10";
    wf_valid = 1; wf_masks = '1;
    repeat (3) tick();
    wf_valid = 0;
    // R2: preload every word
    cur_req = "R2";
    wr_en = 1;
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < ROWS; r++) begin
        wr_bank = BW'(b); wr_row = RW'(r); wr_data = $urandom;
        tick();
      end
    wr_en = 0;
    // R2 R3: lane l reads bank l, each bank its own row
    start('1, 2'd2, 0);
    m = '0;
    for (int l = 0; l < LANES; l++) m[l*LANES + l] = 1'b1;
    send(m, rrows(), roffs());
    drain();
    // R3: broadcast of one bank word to all lanes
    cur_req = "R3";
    start('1, 2'd2, 1);
    m = '0;
    for (int l = 0; l < LANES; l++) m[5*LANES + l] = 1'b1;
    send(m, rrows(), roffs());
    drain();
    // R3: two banks naming a lane, lowest wins
    start('1, 2'd2, 0);
    m = '0;
    for (int l = 0; l < LANES; l++) begin
      m[l*LANES + l] = 1'b1;
      m[((l + 3) % NB)*LANES + l] = 1'b1;
    end
    send(m, rrows(), roffs());
    drain();
    // R4: byte loads, signed and unsigned
    cur_req = "R4";
    repeat (4) one_inst('1, 2'd0, 0);
    repeat (4) one_inst('1, 2'd0, 1);
    // R5: halfword loads
    cur_req = "R5";
    repeat (3) one_inst('1, 2'd1, 0);
    repeat (3) one_inst('1, 2'd1, 1);
    // R6: word and doubleword, including the bank 31 wrap
    cur_req = "R6";
    repeat (2) one_inst('1, 2'd2, 1);
    start('1, 2'd3, 0);
    m = '0;
    for (int l = 0; l < LANES; l++) m[((l * 7) % NB)*LANES + l] = 1'b1;
    send(m, rrows(), roffs());
    drain();
    repeat (2) one_inst('1, 2'd3, 1);
    // R7: partial wavefronts leave other lanes zero
    cur_req = "R7";
    one_inst(32'h0000_f0f1, 2'd2, 0);
    one_inst(32'h8000_0001, 2'd0, 1);
    // R8: stalled register file fills the FIFO and blocks acceptance
    cur_req = "R8";
    wb_ready = 0;
    start('1, 2'd2, 0);
    send(rmask(32'h0000_ffff), rrows(), roffs());
    send(rmask(32'hffff_0000), rrows(), roffs());
    wf_valid = 1; wf_masks = rmask(32'h0000_00ff); wf_rows = rrows();
    repeat (5) tick();
    wf_valid = 0;
    wb_ready = 1;
    drain();
    // R9: restart while open is ignored; empty set retires at once
    cur_req = "R9";
    start(32'h0000_000f, 2'd2, 0);
    start('1, 2'd0, 1);
    send(rmask(32'h0000_0003), rrows(), roffs());
    repeat (3) tick();
    send(rmask(32'h0000_000c), rrows(), roffs());
    drain();
    start('0, 2'd2, 0);
    tick(); tick();
    // R9 R8 R2: random traffic with stalls and colliding writes
    cur_req = "R9";
    for (int n = 0; n < 60; n++) begin
      logic [LANES-1:0] ln, a;
      ln = LANES'($urandom) | 1;
      start(ln, 2'($urandom), 1'($urandom));
      a = ln & LANES'($urandom);
      wr_en = 1'($urandom); wr_bank = BW'($urandom); wr_row = RW'($urandom); wr_data = $urandom;
      wb_ready = 1'($urandom);
      send(rmask(a), rrows(), roffs());
      wr_en = 0;
      wb_ready = 1'($urandom);
      send(rmask(ln & ~a), rrows(), roffs());
      for (int k = 0; k < 300; k++) begin
        if (!m_busy && qm.size() == 0 && !m_inf) break;
        wb_ready = 1'($urandom);
        tick();
      end
      wb_ready = 1;
      tick();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule